// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block owns the program counter of a single-cycle processor. In every clock cycle it presents the current PC for instruction fetch, along with the incremented value PC+4 for use elsewhere in the datapath. It also chooses where execution goes next. Execution can fall through to the next word, move by a PC-relative conditional branch, or go to a pseudo-absolute jump target. The jump target keeps the upper PC bits and replaces the rest with a word index.

The decoder supplies three things: a jump flag, a 3-bit branch-kind code, and the fetched instruction word. The register file supplies the two operands that branches compare. All next-PC logic is combinational and settles within the cycle. A single register captures the chosen value on the rising clock edge. There is no delay slot, so a redirect takes effect at the very next instruction.

Top module: `npc_seq`

## Requirements
- R1: A high `rst` at a rising edge loads PC with 0, so afterwards `pc` reads 0 and `pc_plus4` reads 4.
- R2: With `jump` low and `br_kind` = 0 (no branch), PC advances by 4 at each rising edge.
- R3: `pc_plus4` always equals `pc` + 4 modulo 2^32, so 0xFFFFFFFC gives 0.
- R4: With `jump` high, the next PC is {pc[31:28], instr[25:0], 2'b00}, so the upper four PC bits are kept.
- R5: A taken branch loads pc + 4 + (sign-extended instr[15:0] × 4) modulo 2^32, so negative offsets move backwards and wrap below 0.
- R6: `br_kind` = 1 (equal) is taken exactly when `rs_val` equals `rt_val`.
- R7: `br_kind` = 2 (not equal) is taken exactly when `rs_val` differs from `rt_val`.
- R8: `br_kind` = 3 is taken when `rs_val`, read as signed, is ≤ 0. `rt_val` plays no part.
- R9: `br_kind` = 4 is taken when `rs_val`, read as signed, is > 0. `rt_val` plays no part.
- R10: A branch whose condition fails loads pc + 4.
- R11: When `jump` is high, the jump target is loaded even if a branch condition also holds.
- R12: `br_kind` codes 5, 6 and 7 act as no branch: the next PC is pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word (bits 25:0 jump index, bits 15:0 branch offset) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| jump | input | 1 | Decoded pseudo-absolute jump |
| br_kind | input | 3 | Branch kind: 0 none, 1 equal, 2 not equal, 3 ≤ 0, 4 > 0, 5-7 none |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | pc + 4 |

## Verification
`pc_plus4` is combinational from `pc`, so it is correct in the same cycle that `pc` changes. A control input applied in one cycle reaches `pc` through exactly one register, so it shows up right after the next rising edge. The bench drives every input on a falling edge and checks the outputs on the following falling edge. That edge is half a period after the single register has updated, so each check sees the result of exactly one decision. Reset follows the same one-edge rule.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [2:0] {
        BR_NONE = 3'd0,
        BR_EQ   = 3'd1,
        BR_NE   = 3'd2,
        BR_LEZ  = 3'd3,
        BR_GTZ  = 3'd4
    } br_kind_e;

    typedef enum logic [1:0] {
        SEL_SEQ,
        SEL_BRANCH,
        SEL_JUMP
    } pc_sel_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [2:0]      kind,
    output logic            taken
);
    import npc_pkg::*;

    logic eq;
    logic neg;
    logic zero;

    always_comb begin
        eq   = (op_a == op_b);
        neg  = op_a[XLEN-1];
        zero = (op_a == '0);
        case (kind)
            BR_EQ:   taken = eq;
            BR_NE:   taken = !eq;
            BR_LEZ:  taken = neg || zero;
            BR_GTZ:  taken = !neg && !zero;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN   = 32,
    parameter int JIDX_W = 26,
    parameter int IMM_W  = 16,
    parameter int ALIGN  = 2
) (
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [JIDX_W-1:0] jfield,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc
);
    localparam int KEEP_W = XLEN - JIDX_W - ALIGN;
    localparam int EXT_W  = XLEN - IMM_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = {{(XLEN-ALIGN-1){1'b0}}, 1'b1, {ALIGN{1'b0}}};

    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  offset;

    always_comb begin
        imm    = jfield[IMM_W-1:0];
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
        seq_pc = pc_cur + STEP;
        br_pc  = seq_pc + offset;
        jmp_pc = {pc_cur[XLEN-1 -: KEEP_W], jfield, {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
    parameter int XLEN   = 32,
    parameter int JIDX_W = 26,
    parameter int IMM_W  = 16,
    parameter int ALIGN  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            jump,
    input  logic [2:0]      br_kind,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_plus4
);
    import npc_pkg::*;

    localparam int KEEP_W = XLEN - JIDX_W - ALIGN;
    localparam int EXT_W  = XLEN - IMM_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = {{(XLEN-ALIGN-1){1'b0}}, 1'b1, {ALIGN{1'b0}}};

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t  st_d, st_q;
    pc_sel_e sel_d;
    logic    br_taken_d;
    logic [XLEN-1:0] seq_d, br_d, jmp_d;
    logic    unused_opcode;

    assign unused_opcode = ^instr[XLEN-1:JIDX_W];

    npc_cond #(.XLEN(XLEN)) u_cond (
        .op_a  (rs_val),
        .op_b  (rt_val),
        .kind  (br_kind),
        .taken (br_taken_d)
    );

    npc_target #(.XLEN(XLEN), .JIDX_W(JIDX_W), .IMM_W(IMM_W), .ALIGN(ALIGN)) u_tgt (
        .pc_cur (st_q.pc),
        .jfield (instr[JIDX_W-1:0]),
        .seq_pc (seq_d),
        .br_pc  (br_d),
        .jmp_pc (jmp_d)
    );

    always_comb begin
        if (jump)            sel_d = SEL_JUMP;
        else if (br_taken_d) sel_d = SEL_BRANCH;
        else                 sel_d = SEL_SEQ;
        st_d = st_q;
        case (sel_d)
            SEL_JUMP:   st_d.pc = jmp_d;
            SEL_BRANCH: st_d.pc = br_d;
            default:    st_d.pc = seq_d;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign pc_plus4 = seq_d;

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (pc == '0));

    // R2
    a_r2_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_kind == 3'd0) |=> (pc == $past(pc) + STEP));

    // R4
    a_r4_jump_splice: assert property (@(posedge clk) disable iff (rst)
        jump |=> (pc[XLEN-1 -: KEEP_W] == $past(pc[XLEN-1 -: KEEP_W])
                  && pc[XLEN-KEEP_W-1:ALIGN] == $past(instr[JIDX_W-1:0])
                  && pc[ALIGN-1:0] == '0));

    // R6 and R5
    a_r6_eq_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_kind == 3'd1 && rs_val == rt_val)
        |=> (pc == $past(pc) + STEP
                   + {{EXT_W{$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0]), {ALIGN{1'b0}}}));

    // R10
    a_r10_eq_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_kind == 3'd1 && rs_val != rt_val) |=> (pc == $past(pc) + STEP));

    // R12
    a_r12_unused_codes: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_kind > 3'd4) |=> (pc == $past(pc) + STEP));

    // R3
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc[ALIGN-1:0] == '0 && pc_plus4[ALIGN-1:0] == '0));
endmodule

// File: tb/tb_npc_seq.sv
module tb_npc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
    logic        jump = 1'b0;
    logic [2:0]  br_kind = 3'd0;
    logic [31:0] pc, pc_plus4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    npc_seq dut (
        .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .jump(jump), .br_kind(br_kind), .pc(pc), .pc_plus4(pc_plus4)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        j;
        logic [2:0]  op;
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b0, 3'd0, 32'h0,        32'h0,        32'h0, 32'h04}, // R2
        '{4'd6,  1'b0, 3'd1, 32'h3,        32'h5,        32'h5, 32'h14}, // R6 taken
        '{4'd10, 1'b0, 3'd1, 32'h3,        32'h5,        32'h6, 32'h18}, // R10
        '{4'd7,  1'b0, 3'd2, 32'h10,       32'h1,        32'h2, 32'h5C}, // R7 taken
        '{4'd7,  1'b0, 3'd2, 32'h10,       32'h7,        32'h7, 32'h60}, // R7 not taken
        '{4'd8,  1'b0, 3'd3, 32'hFFFC,     32'h0,        32'h9, 32'h54}, // R8 zero, R5 negative
        '{4'd8,  1'b0, 3'd3, 32'hFFFC,     32'h80000000, 32'h0, 32'h48}, // R8 negative
        '{4'd8,  1'b0, 3'd3, 32'hFFFC,     32'h1,        32'h0, 32'h4C}, // R8 positive
        '{4'd9,  1'b0, 3'd4, 32'h2,        32'h1,        32'h0, 32'h58}, // R9 taken
        '{4'd9,  1'b0, 3'd4, 32'h2,        32'h0,        32'h5, 32'h5C}, // R9 zero
        '{4'd9,  1'b0, 3'd4, 32'h2,        32'h80000000, 32'h0, 32'h60}, // R9 negative
        '{4'd4,  1'b1, 3'd0, 32'h40,       32'h0,        32'h0, 32'h100}, // R4
        '{4'd11, 1'b1, 3'd1, 32'h10,       32'h9,        32'h9, 32'h40}, // R11
        '{4'd12, 1'b0, 3'd5, 32'h8,        32'h3,        32'h3, 32'h44}, // R12
        '{4'd12, 1'b0, 3'd7, 32'h8,        32'h3,        32'h3, 32'h48}, // R12
        '{4'd12, 1'b0, 3'd6, 32'h8,        32'h3,        32'h3, 32'h4C}  // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic j, input logic [2:0] op, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b);
        jump = j; br_kind = op; instr = ins; rs_val = a; rt_val = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 pc after reset", pc, 32'h0);
        check("R3 pc_plus4 after reset", pc_plus4, 32'h4);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].j, TBL[i].op, TBL[i].ins, TBL[i].a, TBL[i].b);
            check($sformatf("R%0d vector %0d pc", TBL[i].req, i), pc, TBL[i].exp);
            check($sformatf("R3 vector %0d pc_plus4", i), pc_plus4, TBL[i].exp + 32'h4);
        end

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", pc, 32'h0);
        rst = 1'b0;

        // R5: negative offset wraps below zero
        apply(1'b0, 3'd1, 32'h0000FFFE, 32'h1, 32'h1);
        check("R5 wrap below zero", pc, 32'hFFFFFFFC);
        check("R3 pc_plus4 wraps to zero", pc_plus4, 32'h0);

        // R4: jump keeps nonzero upper nibble
        apply(1'b1, 3'd0, 32'hFC000123, 32'h0, 32'h0);
        check("R4 jump from high page", pc, 32'hF000048C);

        // R2
        apply(1'b0, 3'd0, 32'h0, 32'h0, 32'h0);
        check("R2 fallthrough high page", pc, 32'hF0000490);

        // R5: largest positive offset
        apply(1'b0, 3'd1, 32'h00007FFF, 32'h2, 32'h2);
        check("R5 max positive offset", pc, 32'hF0020490);

        // R8: rt ignored with equal operands
        apply(1'b0, 3'd3, 32'h4, 32'h5, 32'h5);
        check("R8 rt ignored", pc, 32'hF0020494);

        finish_run();
    end
endmodule